// File: doc/BRIEF.md
# DMA Read Request Chunk Splitter

This block accepts one read job at a time (a start address in host memory and a byte count of any value, including counts that are not a whole number of 32-bit words) and turns it into a stream of memory read requests. Each request carries an address and a byte length. Chunk lengths follow a configured largest transfer size (64, 128 or 256 bytes) and an optional split mode that keeps requests from unaligned addresses inside a 64-byte window. The job is kicked with a one-cycle start, reported busy while it runs, and closed with a one-cycle done pulse.

Flow control is credit based. A programmable limit caps how many requests may be outstanding. Each returned completion releases one slot. The request port uses a valid/ready handshake, and an offered request stays fixed until it is taken. Data movement and response reassembly sit outside this block.

Top module: `rd_chunk_splitter`

## Requirements
- R1: After reset, `req_valid`, `job_busy` and `job_done` are all low.
- R2: `job_start` while idle latches address, length, size code, split mode and credit limit, and raises `job_busy` on the next cycle. `job_start` while busy is ignored, and the running job keeps its addresses.
- R3: Size code `cfg_xfer_size` maps 0 to 64 bytes, 1 to 128 bytes and 2 to 256 bytes. The reserved code 3 behaves as 64 bytes.
- R4: With split mode off, a chunk never crosses an address boundary that is a multiple of the configured size. Its length is the smaller of the remaining bytes and the distance to that boundary.
- R5: With split mode on and a size above 64 bytes, a chunk starting at an address that is not 128-byte aligned stays inside its 64-byte window. A chunk starting at a 128-byte aligned address may reach the configured size.
- R6: Any byte count is accepted. The final chunk carries exactly the bytes left, which may be an odd number. No request has length zero.
- R7: The first request uses the job address. Each later request starts at the previous address plus the previous length, and the lengths sum to the job byte count.
- R8: The credit limit is `cfg_max_pend` clamped to 1..12: 0 acts as 1 and values above 12 act as 12. `req_valid` is high exactly when the job is busy, bytes remain, and fewer requests than the limit are outstanding.
- R9: A `cpl_valid` pulse frees one outstanding slot. A pulse when nothing is outstanding is ignored.
- R10: While `req_valid` is high and `req_ready` is low, the request stays valid and its address and length do not change.
- R11: `job_done` is a one-cycle pulse in the cycle after the edge at which the last completion returns with no bytes left. `job_busy` falls at that same edge. A zero-length job completes in the second cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_pend | input | 4 | Requested credit limit, sampled at job start |
| cfg_xfer_size | input | 2 | Largest chunk size code, sampled at job start |
| cfg_split_en | input | 1 | Alignment-aware split mode, sampled at job start |
| job_start | input | 1 | One-cycle job kick |
| job_addr | input | ADDR_W | Job start byte address |
| job_len | input | LEN_W | Job byte count |
| job_busy | output | 1 | Job in progress |
| job_done | output | 1 | One-cycle job completion pulse |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Request byte address |
| req_len | output | 9 | Request byte length (1..256) |
| cpl_valid | input | 1 | One read completion returned |

## Verification
The bench targets chunk lengths at awkward addresses: an offset just past a 64-byte line with split on, a 128-aligned address that is not 256-aligned, and a job that ends in a single odd byte. A sizer that confused the two windows would emit a chunk straddling a line, or one that is too short. It holds completions back so the credit gate must close at exactly 1 and exactly 12; a missing clamp would issue 15, or stall forever on a limit of 0. A stray completion while idle and a second start during a job would, if honoured, wrap the slot count or redirect the address stream. Back-pressure cycles check that an offered request is neither advanced nor dropped, and zero-length and last-completion cases check that the done pulse lands in its exact cycle.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Largest chunk is 256 bytes, so a chunk length fits in nine bits.
    localparam int unsigned CHUNK_W = 9;

    typedef enum logic [1:0] {
        XS_64   = 2'd0,
        XS_128  = 2'd1,
        XS_256  = 2'd2,
        XS_RSVD = 2'd3
    } xfer_sel_e;

    // Credit limit: zero would deadlock, so it becomes one; above cap is cut to cap.
    function automatic logic [3:0] clamp_credit(input logic [3:0] raw, input logic [3:0] cap);
        if (raw == 4'd0) return 4'd1;
        if (raw > cap)   return cap;
        return raw;
    endfunction

    function automatic logic [CHUNK_W-1:0] xfer_bytes(input xfer_sel_e sel);
        case (sel)
            XS_128:  return 9'd128;
            XS_256:  return 9'd256;
            default: return 9'd64;   // XS_64 and the reserved code
        endcase
    endfunction

endpackage

// File: rtl/rcs_chunk_sizer.sv
module rcs_chunk_sizer
    import rcs_pkg::*;
#(
    parameter int unsigned LEN_W = 16   // must be at least CHUNK_W
) (
    input  logic [7:0]         addr_lo,
    input  logic [LEN_W-1:0]   remain,
    input  xfer_sel_e          xfer,
    input  logic               split_en,
    output logic [CHUNK_W-1:0] chunk_len,
    output logic [CHUNK_W-1:0] cap_bytes
);

    logic               narrow;
    logic [CHUNK_W-1:0] window;
    logic [CHUNK_W-1:0] offset;
    logic [CHUNK_W-1:0] to_edge;

    always_comb begin
        cap_bytes = xfer_bytes(xfer);
        // Split mode: off a 128-byte grid, keep inside the current 64-byte line.
        narrow    = split_en && (cap_bytes > 9'd64) && (addr_lo[6:0] != 7'd0);
        window    = narrow ? 9'd64 : cap_bytes;
        offset    = {1'b0, addr_lo} & (window - 9'd1);
        to_edge   = window - offset;
        if (remain < LEN_W'(to_edge)) chunk_len = remain[CHUNK_W-1:0];
        else                          chunk_len = to_edge;
    end

endmodule

// File: rtl/rcs_credit_ctr.sv
module rcs_credit_ctr
    import rcs_pkg::*;
#(
    parameter logic [3:0] CAP = 4'd12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [3:0] cfg_raw,
    input  logic       issue,
    input  logic       slot_free,
    output logic       grant,
    output logic       drain_next
);

    typedef struct packed {
        logic [3:0] limit;
        logic [3:0] used;
    } cred_t;

    cred_t st_d, st_q;
    logic  free_ok;

    always_comb begin
        st_d    = st_q;
        free_ok = slot_free && (st_q.used != 4'd0);
        if (load) st_d.limit = clamp_credit(cfg_raw, CAP);
        case ({issue, free_ok})
            2'b10:   st_d.used = st_q.used + 4'd1;
            2'b01:   st_d.used = st_q.used - 4'd1;
            default: st_d.used = st_q.used;
        endcase
        grant      = st_q.used < st_q.limit;
        drain_next = (st_d.used == 4'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{limit: 4'd1, used: 4'd0};
        else        st_q <= st_d;
    end

    // R8: outstanding count never passes the latched limit
    a_r8_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.used <= st_q.limit);

    // R8: the request side issues only while a slot is free
    a_r8_issue_granted: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> grant);

    // R9: a completion with nothing outstanding leaves the count at zero
    a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_free && !issue && st_q.used == 4'd0) |=> (st_q.used == 4'd0));

    // R9: a completion alone returns exactly one slot
    a_r9_slot_return: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_free && !issue && st_q.used != 4'd0) |=> (st_q.used == $past(st_q.used) - 4'd1));

endmodule

// File: rtl/rcs_job_ctrl.sv
module rcs_job_ctrl
    import rcs_pkg::*;
#(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned LEN_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [LEN_W-1:0]   start_len,
    input  logic [1:0]         cfg_xfer,
    input  logic               cfg_split,
    input  logic               fire,
    input  logic [CHUNK_W-1:0] chunk_len,
    input  logic               drain_next,
    output logic               load,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [LEN_W-1:0]   remain,
    output xfer_sel_e          xfer,
    output logic               split
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        xfer_sel_e         xfer;
        logic              split;
    } job_t;

    job_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = start && !st_q.busy;
        if (load) begin
            st_d.busy   = 1'b1;
            st_d.addr   = start_addr;
            st_d.remain = start_len;
            st_d.xfer   = xfer_sel_e'(cfg_xfer);
            st_d.split  = cfg_split;
        end else if (st_q.busy) begin
            if (fire) begin
                st_d.addr   = st_q.addr + ADDR_W'(chunk_len);
                st_d.remain = st_q.remain - LEN_W'(chunk_len);
            end
            if ((st_d.remain == '0) && drain_next) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{busy: 1'b0, done: 1'b0, addr: '0, remain: '0, xfer: XS_64, split: 1'b0};
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign cur_addr = st_q.addr;
    assign remain   = st_q.remain;
    assign xfer     = st_q.xfer;
    assign split    = st_q.split;

    // R11: done lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R2: a start during a job does not move the job
    a_r2_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start && !fire) |=> ($stable(st_q.addr) && $stable(st_q.remain)));

    // R7: each accepted chunk advances the address by its length
    a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.addr == $past(st_q.addr) + ADDR_W'($past(chunk_len))));

endmodule

// File: rtl/rd_chunk_splitter.sv
module rd_chunk_splitter
    import rcs_pkg::*;
#(
    parameter int unsigned ADDR_W   = 40,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned PEND_CAP = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         cfg_max_pend,
    input  logic [1:0]         cfg_xfer_size,
    input  logic               cfg_split_en,
    input  logic               job_start,
    input  logic [ADDR_W-1:0]  job_addr,
    input  logic [LEN_W-1:0]   job_len,
    output logic               job_busy,
    output logic               job_done,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [CHUNK_W-1:0] req_len,
    input  logic               cpl_valid
);

    logic               load;
    logic               fire;
    logic               grant;
    logic               drain_next;
    logic [LEN_W-1:0]   remain;
    xfer_sel_e          xfer;
    logic               split;
    logic [CHUNK_W-1:0] chunk_len;
    logic [CHUNK_W-1:0] cap_bytes;

    rcs_job_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_job (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (job_start),
        .start_addr (job_addr),
        .start_len  (job_len),
        .cfg_xfer   (cfg_xfer_size),
        .cfg_split  (cfg_split_en),
        .fire       (fire),
        .chunk_len  (chunk_len),
        .drain_next (drain_next),
        .load       (load),
        .busy       (job_busy),
        .done       (job_done),
        .cur_addr   (req_addr),
        .remain     (remain),
        .xfer       (xfer),
        .split      (split)
    );

    rcs_chunk_sizer #(.LEN_W(LEN_W)) u_size (
        .addr_lo   (req_addr[7:0]),
        .remain    (remain),
        .xfer      (xfer),
        .split_en  (split),
        .chunk_len (chunk_len),
        .cap_bytes (cap_bytes)
    );

    rcs_credit_ctr #(.CAP(4'(PEND_CAP))) u_cred (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_raw    (cfg_max_pend),
        .issue      (fire),
        .slot_free  (cpl_valid),
        .grant      (grant),
        .drain_next (drain_next)
    );

    assign req_valid = job_busy && (remain != '0) && grant;
    assign req_len   = chunk_len;
    assign fire      = req_valid && req_ready;

    // R10: an offered request holds until taken
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

    // R6: a request is never empty and never exceeds what is left
    a_r6_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_len != '0) && (LEN_W'(req_len) <= remain)));

    // R4: without split mode, no chunk crosses a size-multiple boundary
    a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !split) |->
        ((10'({1'b0, req_addr[7:0]} & (cap_bytes - 9'd1)) + 10'(req_len)) <= 10'(cap_bytes)));

    // R5: with split mode, unaligned starts stay inside one 64-byte line
    a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && split && (cap_bytes > 9'd64) && (req_addr[6:0] != 7'd0)) |->
        ((10'(req_addr[5:0]) + 10'(req_len)) <= 10'd64));

    // R11: done is never reported while still busy
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |-> !job_busy);

endmodule

// File: tb/tb_rd_chunk_splitter.sv
module tb_rd_chunk_splitter;

    localparam int NV = 8;
    localparam logic [39:0] V_ADDR  [NV] = '{40'h1000, 40'h1010, 40'h1010, 40'h2000,
                                             40'h20F3, 40'h3080, 40'h4005, 40'h4001};
    localparam int          V_LEN   [NV] = '{300, 200, 200, 513, 7, 400, 3, 130};
    localparam int          V_XFER  [NV] = '{0, 1, 1, 2, 2, 2, 3, 3};
    localparam int          V_SPLIT [NV] = '{0, 0, 1, 0, 1, 1, 0, 1};
    localparam int          V_PEND  [NV] = '{2, 12, 1, 0, 4, 15, 3, 2};
    localparam int          V_HOLD  [NV] = '{0, 5, 0, 3, 0, 6, 0, 2};
    localparam int          V_RMODE [NV] = '{0, 1, 0, 1, 0, 0, 0, 1};
    localparam int          V_FIRST [NV] = '{64, 112, 48, 256, 7, 128, 3, 63};
    localparam int          V_COUNT [NV] = '{5, 2, 3, 3, 1, 3, 1, 3};
    localparam int          V_CAPCK [NV] = '{0, 0, 0, 1, 0, 0, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_max_pend = '0;
    logic [1:0]  cfg_xfer_size = '0;
    logic        cfg_split_en = 1'b0;
    logic        job_start = 1'b0;
    logic [39:0] job_addr = '0;
    logic [15:0] job_len = '0;
    logic        job_busy, job_done, req_valid;
    logic        req_ready = 1'b0;
    logic [39:0] req_addr;
    logic [8:0]  req_len;
    logic        cpl_valid = 1'b0;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  ended = 1'b0;

    always #4 clk = ~clk;

    rd_chunk_splitter dut (
        .clk(clk), .rst_n(rst_n), .cfg_max_pend(cfg_max_pend), .cfg_xfer_size(cfg_xfer_size),
        .cfg_split_en(cfg_split_en), .job_start(job_start), .job_addr(job_addr), .job_len(job_len),
        .job_busy(job_busy), .job_done(job_done), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cpl_valid(cpl_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Chunk length from R3, R4, R5 and R6.
    function automatic int model_len(input logic [39:0] a, input int rem, input int x, input int s);
        int mx, win, off, te;
        mx  = (x == 1) ? 128 : (x == 2) ? 256 : 64;
        win = (s != 0 && mx > 64 && a[6:0] != 7'd0) ? 64 : mx;
        off = int'(a[7:0]) % win;
        te  = win - off;
        return (rem < te) ? rem : te;
    endfunction

    task automatic run_job(input logic [39:0] a, input int l, input int x, input int s,
                           input int p, input int hold, input int rmode, input int exp_first,
                           input int exp_cnt, input bit poke, input int cap_chk);
        logic [39:0] ea, st_addr;
        int rem, bout, lim, nfire, cyc, el, st_len;
        bit exp_done, finished, stall;
        lim = (p == 0) ? 1 : (p > 12 ? 12 : p);
        @(negedge clk);
        cfg_max_pend = 4'(p); cfg_xfer_size = 2'(x); cfg_split_en = 1'(s);
        job_addr = a; job_len = 16'(l); job_start = 1'b1;
        @(negedge clk);
        job_start = 1'b0;
        ea = a; rem = l; bout = 0; nfire = 0; cyc = 0;
        exp_done = 1'b0; finished = 1'b0; stall = 1'b0; st_addr = '0; st_len = 0;
        while (!finished && cyc < 3000) begin
            check(job_done === exp_done, "R11 done timing", longint'(job_done), longint'(exp_done));
            if (exp_done) begin
                check(job_busy === 1'b0, "R11 busy falls with done", longint'(job_busy), 0);
                finished = 1'b1;
            end else begin
                check(job_busy === 1'b1, "R2 busy during job", longint'(job_busy), 1);
                check(req_valid === (rem > 0 && bout < lim), "R8 credit gate",
                      longint'(req_valid), longint'(rem > 0 && bout < lim));
                if (stall) begin
                    check(req_valid && req_addr == st_addr && int'(req_len) == st_len,
                          "R10 stalled request held", longint'(req_len), longint'(st_len));
                end
                if (cap_chk > 0 && cyc == hold)
                    check(nfire == cap_chk, "R8 issued count at limit", nfire, cap_chk);
                req_ready = (rmode == 1) ? (cyc % 3 != 1) : 1'b1;
                cpl_valid = (cyc >= hold) && (bout > 0);
                job_start = (poke && cyc == 1);
                if (poke && cyc == 1) begin
                    job_addr = 40'hABC00; job_len = 16'd5;
                end
                if (req_valid && req_ready) begin
                    el = model_len(ea, rem, x, s);
                    check(req_addr == ea, "R7 request address", longint'(req_addr), longint'(ea));
                    check(int'(req_len) == el, "R4 R5 R6 chunk length", longint'(req_len), el);
                    if (nfire == 0)
                        check(int'(req_len) == exp_first, "R3 first chunk", longint'(req_len), exp_first);
                    ea = ea + 40'(el); rem = rem - el; nfire++; bout++;
                end
                stall = req_valid && !req_ready;
                st_addr = req_addr; st_len = int'(req_len);
                if (cpl_valid) bout--;
                exp_done = (rem == 0 && bout == 0);
                cyc++;
                @(negedge clk);
                job_start = 1'b0;
                cpl_valid = 1'b0;
            end
        end
        check(finished, "R11 job finished", longint'(finished), 1);
        check(nfire == exp_cnt, "R7 chunk count", nfire, exp_cnt);
        req_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_valid === 1'b0, "R1 req_valid at reset", longint'(req_valid), 0);
        check(job_busy === 1'b0, "R1 busy at reset", longint'(job_busy), 0);
        check(job_done === 1'b0, "R1 done at reset", longint'(job_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_valid === 1'b0, "R1 idle after reset", longint'(req_valid), 0);

        for (int i = 0; i < NV; i++)
            run_job(V_ADDR[i], V_LEN[i], V_XFER[i], V_SPLIT[i], V_PEND[i], V_HOLD[i],
                    V_RMODE[i], V_FIRST[i], V_COUNT[i], 1'b0, V_CAPCK[i]);

        // R8: clamp 15 to 12 with completions held back; R2: start while busy ignored
        run_job(40'h0, 1280, 0, 0, 15, 30, 0, 64, 20, 1'b1, 12);

        // R9: stray completion while idle must not disturb the slot count
        @(negedge clk); cpl_valid = 1'b1;
        @(negedge clk); cpl_valid = 1'b0;
        check(req_valid === 1'b0, "R9 idle after stray completion", longint'(req_valid), 0);
        run_job(40'h5000, 200, 0, 0, 1, 4, 0, 64, 4, 1'b0, 1);

        // R11: zero-length job
        run_job(40'h6000, 0, 2, 0, 3, 0, 0, 0, 0, 1'b0, 0);

        // R6: single odd byte at a 64-byte line end with split on
        run_job(40'h703F, 1, 1, 1, 2, 0, 0, 1, 1, 1'b0, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule